// File: doc/BRIEF.md
# Serial Synapse Configuration Chain

This block holds the connectivity setting of every synapse in a spiking network array. Each synapse cell keeps a two-bit state that marks the contact as absent, excitatory or inhibitory. All cells are linked into one long shift register. A built-in loader walks a parallel configuration image into the register one bit at a time, most significant bit first, and moves one bit for each configuration tick. A configuration tick comes once every `CLK_DIV` cycles of the system clock, which keeps the shift rate within the limit of the analog array. The loader reports `busy` while it shifts and pulses `done` when the whole image is in place.

Each cell decodes its bit pair into separate enables for its excitatory and its inhibitory branch. The array can keep running while the chain is rewritten. With `live_upd` low, the branch enables keep their old values during the load and all switch together one cycle after `done`. With `live_upd` high, the enables follow the chain contents through the load. A cell that ends a load holding the illegal pattern (both bits set) is treated as unconnected, and a sticky error flag is raised. The tail bit of the chain is brought out on `ser_out`, so several chains can be cascaded or the previous contents read back.

Top module: `syn_cfg_chain`

## Requirements
- R1: While `rst_n` is low, every cell, all branch enables, `cfg_err`, `busy`, `done` and `ser_out` are 0.
- R2: A `start` sampled while idle raises `busy` in the next cycle. The chain then moves one bit every `CLK_DIV` cycles, for 2*`CELLS` moves. `done` is high for exactly one cycle, after the edge that made the last move, and `busy` falls on that same edge. `done` is therefore first high 2*`CELLS`*`CLK_DIV` cycles after the cycle in which `start` was sampled.
- R3: At move j (counting from 0), `cfg_image[2*CELLS-1-j]` enters the chain head (bit 0). Every chain bit i moves to bit i+1. `ser_out` shows chain bit 2*`CELLS`-1, so during a load it gives the previous contents, most significant bit first.
- R4: After a load, cell k holds b0 = `cfg_image[2k+1]` and b1 = `cfg_image[2k]`. Its outputs are `exc_en[k]` = b0 AND NOT b1 and `inh_en[k]` = b1 AND NOT b0. The pair 00 means no connection, and `exc_en` and `inh_en` are never high for the same cell.
- R5: The pair 11 drives neither enable. If any cell holds 11 when `done` is high, `cfg_err` goes to 1 on the next edge. It then stays 1 through any later loads until reset.
- R6: With `live_upd` high, the enables show the decoded chain contents as they were one cycle earlier, also between moves.
- R7: With `live_upd` low, the enables stay unchanged during a load. They take the decoded new contents one cycle after `done`.
- R8: `start` is ignored while `busy` is high. The load in progress keeps its timing and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| start | input | 1 | Begin a load of `cfg_image` |
| live_upd | input | 1 | 1: enables follow the chain; 0: enables update only at completion |
| cfg_image | input | 2*CELLS | Parallel configuration image, held stable during a load |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse after the final move |
| ser_out | output | 1 | Tail bit of the chain |
| exc_en | output | CELLS | Excitatory branch enable per cell |
| inh_en | output | CELLS | Inhibitory branch enable per cell |
| cfg_err | output | 1 | Sticky flag: an illegal 11 pair was loaded |

## Verification
The hardest state to reach from the ports is the chain part-way through a load, where half-shifted bit pairs drive the live enables and `ser_out` shows bits left over from the previous image. The bench keeps its own model of the chain, built only from the shift order in R3, and moves it on every tick. In live mode it compares the enables against that model on every cycle of the load. It follows one image with a different image, so `ser_out` can be traced bit by bit. To check that the error flag stays set, an image containing a 11 pair is loaded and a clean image is loaded after it.

// File: rtl/syn_cfg_chain.sv
module syn_cfg_chain #(
  parameter int CELLS   = 2048,
  parameter int CLK_DIV = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               live_upd,
  input  logic [2*CELLS-1:0] cfg_image,
  output logic               busy,
  output logic               done,
  output logic               ser_out,
  output logic [CELLS-1:0]   exc_en,
  output logic [CELLS-1:0]   inh_en,
  output logic               cfg_err
);
  localparam int BITS = 2 * CELLS;
  localparam int IW   = (BITS > 1) ? $clog2(BITS) : 1;
  localparam int DW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [BITS-1:0]  chain;
  logic [IW-1:0]    idx;
  logic [DW-1:0]    dcnt;
  logic             tick;
  logic [CELLS-1:0] exc_nx, inh_nx, bad;

  assign tick    = (dcnt == DW'(CLK_DIV - 1));
  assign ser_out = chain[BITS-1];

  // loader: one move per tick, MSB of the image first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      idx   <= '0;
      dcnt  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          idx  <= '0;
          dcnt <= '0;
        end
      end else if (tick) begin
        dcnt  <= '0;
        chain <= {chain[BITS-2:0], cfg_image[BITS-1-int'(idx)]};
        idx   <= idx + 1'b1;
        if (idx == IW'(BITS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  // per-cell decode: b0 = chain[2k+1] excitatory, b1 = chain[2k] inhibitory
  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    assign exc_nx[k] =  chain[2*k+1] & ~chain[2*k];
    assign inh_nx[k] =  chain[2*k]   & ~chain[2*k+1];
    assign bad[k]    =  chain[2*k+1] &  chain[2*k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_en  <= '0;
      inh_en  <= '0;
      cfg_err <= 1'b0;
    end else begin
      if (live_upd || done) begin
        exc_en <= exc_nx;
        inh_en <= inh_nx;
      end
      if (done && |bad) cfg_err <= 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));  // R2
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));  // R2
  AST_EXCL_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en & inh_en) == '0);  // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);  // R5
  AST_HOLD_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (!live_upd && !done) |=> ($stable(exc_en) && $stable(inh_en)));  // R7
endmodule

// File: tb/syn_cfg_chain_tb.sv
module syn_cfg_chain_tb;
  localparam int N   = 8;
  localparam int DIV = 2;
  localparam int B   = 2 * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         live_upd = 1'b0;
  logic [B-1:0] cfg_image = '0;
  logic         busy, done, ser_out, cfg_err;
  logic [N-1:0] exc_en, inh_en;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [B-1:0] mdl = '0;
  logic         errm = 1'b0;

  always #2.5 clk = ~clk;

  syn_cfg_chain #(.CELLS(N), .CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .live_upd(live_upd),
    .cfg_image(cfg_image), .busy(busy), .done(done), .ser_out(ser_out),
    .exc_en(exc_en), .inh_en(inh_en), .cfg_err(cfg_err)
  );

  function automatic logic [B-1:0] dec(input logic [B-1:0] s);
    logic [N-1:0] e, i;
    for (int k = 0; k < N; k++) begin
      e[k] = s[2*k+1] & ~s[2*k];
      i[k] = s[2*k] & ~s[2*k+1];
    end
    return {e, i};
  endfunction

  function automatic logic has11(input logic [B-1:0] s);
    logic r = 1'b0;
    for (int k = 0; k < N; k++) r |= s[2*k+1] & s[2*k];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [B-1:0] img, input bit live, input bit poke);
    logic [B-1:0] pm;
    logic [B-1:0] hold_v = {exc_en, inh_en};
    @(negedge clk);
    cfg_image = img; live_upd = live; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2", "busy after start", 64'(busy), 64'd1);
    for (int c = 1; c <= B * DIV; c++) begin
      @(negedge clk);
      start = 1'b0;
      pm = mdl;
      if (c % DIV == 0) mdl = {mdl[B-2:0], img[B - c / DIV]};
      if (c < B * DIV)
        chk(busy === 1'b1 && done === 1'b0, "R2", "busy mid load", 64'({busy, done}), 64'b10);
      else
        chk(busy === 1'b0 && done === 1'b1, "R2", "done at end", 64'({busy, done}), 64'b01);
      if (c % DIV == 0)
        chk(ser_out === mdl[B-1], "R3", "ser_out", 64'(ser_out), 64'(mdl[B-1]));
      if (live)
        chk({exc_en, inh_en} === dec(pm), "R6", "live enables", 64'({exc_en, inh_en}), 64'(dec(pm)));
      else
        chk({exc_en, inh_en} === hold_v, "R7", "held enables", 64'({exc_en, inh_en}), 64'(hold_v));
      chk(cfg_err === errm, "R5", "err during load", 64'(cfg_err), 64'(errm));
      if (poke && c == 10) start = 1'b1;  // R8: ignored while busy
    end
    @(negedge clk);
    errm = errm | has11(img);
    chk({exc_en, inh_en} === dec(img), "R4", "decoded enables", 64'({exc_en, inh_en}), 64'(dec(img)));
    chk(done === 1'b0, "R2", "done single cycle", 64'(done), 64'd0);
    chk(cfg_err === errm, "R5", "err after load", 64'(cfg_err), 64'(errm));
  endtask

  task automatic t_reset_state();
    chk({busy, done, ser_out, cfg_err} === 4'b0, "R1", "flags in reset", 64'({busy, done, ser_out, cfg_err}), 64'd0);
    chk({exc_en, inh_en} === '0, "R1", "enables in reset", 64'({exc_en, inh_en}), 64'd0);
  endtask

  task automatic t_reset_mid_load();
    @(negedge clk);
    cfg_image = 16'h5A18; live_upd = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    t_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    mdl = '0; errm = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && cfg_err === 1'b0, "R1", "idle after reset", 64'({busy, cfg_err}), 64'd0);
    chk({exc_en, inh_en} === '0, "R1", "chain cleared", 64'({exc_en, inh_en}), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    load(16'h9261, 1'b0, 1'b0);  // R4 R7 hold mode
    load(16'h5A18, 1'b1, 1'b0);  // R3 R6 live mode, old bits on ser_out
    load(16'hE46C, 1'b0, 1'b1);  // R5 illegal pair, R8 restart ignored
    load(16'h9261, 1'b1, 1'b0);  // R5 sticky after clean load
    t_reset_mid_load();          // R1
    load(16'h9261, 1'b0, 1'b1);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule